// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

This block is an up-counter with a small control register that picks one of four operating modes: halted with the count held at zero, free-running, restart on a chosen edge of an external trigger pin, or restart when the count meets compare value 0. It advances by one on each cycle where the count-tick input is high. The tick is expected to come from a prescaler that sits outside the block. A wrap from the all-ones value back to zero raises an overflow flag. Software can also raise or lower that flag.

Two compare values drive a toggling timer output. A control bit lets edges on the trigger pin toggle that output as well. The trigger pin passes through a synchronizer before edge detection. A 2-bit edge-select input chooses which transitions count as valid edges. Software accesses the block through a one-byte control register, written with a write strobe and readable at all times. The counter width defaults to 16 bits.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control register reads 00H, the count is zero and the timer output is 0.
- R2: Control bits [7:4] always read 0 and writes to them have no effect. Bits [3:2] are the mode field, bit 1 is the trigger-toggle select and bit 0 is the overflow flag.
- R3: When the mode field is 00, the count is forced to zero on the next clock edge and stays there whatever the tick. The timer output holds its level in this mode.
- R4: In modes 01, 10 and 11, each clock edge with the tick high raises the count by one, unless a restart happens on that edge. With the tick low and no restart, the count holds.
- R5: In modes 01, 10 and 11, a ticked step from the all-ones value to zero sets the overflow flag.
- R6: A write with bit 0 set raises the overflow flag and a write with bit 0 clear lowers it. When a hardware wrap and a software clear fall on the same edge, the flag ends up set.
- R7: Writing mode 00 clears the overflow flag, even if the same write has bit 0 set. The flag stays clear while the mode remains 00.
- R8: In mode 10, a valid trigger edge loads zero into the count on the following edge, whatever the tick. A trigger level applied before clock edge k takes effect at edge k+2.
- R9: In mode 11, a ticked cycle with the count equal to compare value 0 loads zero on that edge instead of incrementing, which gives a period of compare0+1 ticks. This restart never sets the overflow flag, even when compare0 is all ones.
- R10: In a running mode, the timer output inverts on every ticked cycle where the count equals compare value 0 or compare value 1. A cycle where both match inverts it once.
- R11: With bit 1 set and a running mode, a valid trigger edge also inverts the timer output. A trigger edge and a match on the same cycle invert it once.
- R12: The edge-select encoding is 00 for falling edges, 01 for rising edges, 10 for no edges and 11 for both edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count enable for this cycle (prescaled tick) |
| trig_in | input | 1 | External trigger, asynchronous |
| trig_edge_sel | input | 2 | Valid trigger edge: 00 fall, 01 rise, 10 none, 11 both |
| cmp0 | input | CNT_W | Compare value 0 (match restart and output toggle) |
| cmp1 | input | CNT_W | Compare value 1 (output toggle) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| count | output | CNT_W | Current count |
| tout | output | 1 | Timer output |

## Verification
A wrong count or a missed restart shows on `count` at the very next clock edge. A lost overflow or a priority error shows in bit 0 of `ctl_rdata` one edge after the wrap. A toggle that is missed, doubled or made while the counter is stopped leaves `tout` at the wrong level from the next edge onward, and every later comparison keeps showing the error. A synchronizer latency off by one cycle shifts the trigger restart by one edge, so the count departs from the expected value at once.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   localparam int CTL_W       = 8;
   localparam int OVF_BIT     = 0;
   localparam int TSEL_BIT    = 1;
   localparam int MODE_LSB    = 2;
   localparam int MODE_MSB    = 3;

   typedef enum logic [1:0] {
      MODE_STOP  = 2'b00,
      MODE_FREE  = 2'b01,
      MODE_TRIG  = 2'b10,
      MODE_MATCH = 2'b11
   } tmr_mode_e;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_NONE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

endpackage

// File: rtl/tmr16_trig_edge.sv
module tmr16_trig_edge
   import tmr16_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig_in,
   input  edge_sel_e edge_sel,
   output logic      trig_ev
);

   localparam int CHAIN_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr16_trig_edge: SYNC_STAGES must be at least 2");
   end

   // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] the one before
   logic [CHAIN_W-1:0] chain_q;
   logic               lvl_now, lvl_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], trig_in};
   end

   assign lvl_now = chain_q[SYNC_STAGES-1];
   assign lvl_old = chain_q[SYNC_STAGES];

   always_comb begin
      unique case (edge_sel)
         EDGE_FALL: trig_ev = lvl_old & ~lvl_now;
         EDGE_RISE: trig_ev = ~lvl_old & lvl_now;
         EDGE_NONE: trig_ev = 1'b0;
         EDGE_BOTH: trig_ev = lvl_old ^ lvl_now;
         default:   trig_ev = 1'b0;
      endcase
   end

   // R12: the reserved select never yields an event
   a_r12_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel == EDGE_NONE) |-> !trig_ev);

endmodule

// File: rtl/tmr16_ctl_reg.sv
module tmr16_ctl_reg
   import tmr16_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   input  logic             hw_ovf,
   output tmr_mode_e        mode,
   output logic             tsel,
   output logic             ovf,
   output logic [CTL_W-1:0] rdata
);

   tmr_mode_e mode_q, mode_d;
   logic      tsel_q, tsel_d;
   logic      ovf_q,  ovf_d;
   logic      unused_rsvd;

   assign unused_rsvd = ^wdata[CTL_W-1:MODE_MSB+1];

   always_comb begin
      mode_d = mode_q;
      tsel_d = tsel_q;
      if (wr_en) begin
         mode_d = tmr_mode_e'(wdata[MODE_MSB:MODE_LSB]);
         tsel_d = wdata[TSEL_BIT];
      end
      // hardware wrap beats a software clear
      if (hw_ovf)     ovf_d = 1'b1;
      else if (wr_en) ovf_d = wdata[OVF_BIT];
      else            ovf_d = ovf_q;
      // a halted counter always shows a clear flag
      if (mode_d == MODE_STOP) ovf_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_STOP;
         tsel_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         tsel_q <= tsel_d;
         ovf_q  <= ovf_d;
      end
   end

   assign mode = mode_q;
   assign tsel = tsel_q;
   assign ovf  = ovf_q;

   always_comb begin
      rdata                    = '0;
      rdata[MODE_MSB:MODE_LSB] = mode_q;
      rdata[TSEL_BIT]          = tsel_q;
      rdata[OVF_BIT]           = ovf_q;
   end

   // R2: reserved bits read back as zero
   a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[CTL_W-1:MODE_MSB+1] == '0);

   // R6: wrap wins over a same-edge clear unless the write stops the counter
   a_r6_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_ovf && !(wr_en && wdata[MODE_MSB:MODE_LSB] == 2'b00)) |=> ovf_q);

   // R7: a stop write clears the flag
   a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[MODE_MSB:MODE_LSB] == 2'b00) |=> !ovf_q);

   // R7: the flag stays clear while halted
   a_r7_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STOP && !wr_en) |=> !ovf_q);

endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core
   import tmr16_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int N_CMP = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  tmr_mode_e                   mode,
   input  logic                        tick,
   input  logic                        trig_ev,
   input  logic [N_CMP-1:0][CNT_W-1:0] cmp,
   output logic [CNT_W-1:0]            cnt,
   output logic                        run,
   output logic                        match_any,
   output logic                        hw_ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tmr16_count_core: CNT_W must lie in 2..32");
   end
   if (N_CMP < 1) begin : g_bad_ncmp
      $error("tmr16_count_core: N_CMP must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [N_CMP-1:0] hit;
   logic             restart;

   assign run = (mode != MODE_STOP);

   for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
      assign hit[g] = run && tick && (cnt_q == cmp[g]);
   end

   assign match_any = |hit;

   always_comb begin
      unique case (mode)
         MODE_TRIG:  restart = trig_ev;
         MODE_MATCH: restart = hit[0];
         default:    restart = 1'b0;
      endcase
   end

   assign hw_ovf = run && tick && !restart && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R3: halted mode drives the count to zero
   a_r3_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

   // R4: no tick and no restart leaves the count alone
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && !restart) |=> (cnt_q == $past(cnt_q)));

   // R4: a ticked step adds one
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !restart) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R8/R9: a restart lands on zero
   a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run && restart) |=> (cnt_q == '0));

   // R5: a wrap lands on zero
   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hw_ovf |=> (cnt_q == '0));

endmodule

// File: rtl/tmr16_out_tog.sv
module tmr16_out_tog (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tsel,
   input  logic match_any,
   input  logic trig_ev,
   output logic tout
);

   logic tout_q;
   logic flip;

   assign flip = run && (match_any || (tsel && trig_ev));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tout_q <= 1'b0;
      else if (flip) tout_q <= ~tout_q;
   end

   assign tout = tout_q;

   // R3: output frozen while halted
   a_r3_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(tout_q));

   // R10: a compare match inverts the output
   a_r10_match_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (run && match_any) |=> (tout_q != $past(tout_q)));

   // R11: a selected trigger edge inverts the output
   a_r11_trig_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tsel && trig_ev) |=> (tout_q != $past(tout_q)));

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
   import tmr16_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_tick,
   input  logic             trig_in,
   input  logic [1:0]       trig_edge_sel,
   input  logic [CNT_W-1:0] cmp0,
   input  logic [CNT_W-1:0] cmp1,
   input  logic             ctl_we,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   output logic [CNT_W-1:0] count,
   output logic             tout
);

   localparam int N_CMP = 2;

   tmr_mode_e                   mode;
   logic                        tsel, ovf, trig_ev, run, match_any, hw_ovf;
   logic [N_CMP-1:0][CNT_W-1:0] cmp_vec;
   logic                        unused_ovf;

   assign cmp_vec    = {cmp1, cmp0};
   assign unused_ovf = ovf;

   tmr16_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .edge_sel (edge_sel_e'(trig_edge_sel)),
      .trig_ev  (trig_ev)
   );

   tmr16_ctl_reg u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ctl_we),
      .wdata  (ctl_wdata),
      .hw_ovf (hw_ovf),
      .mode   (mode),
      .tsel   (tsel),
      .ovf    (ovf),
      .rdata  (ctl_rdata)
   );

   tmr16_count_core #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .tick      (cnt_tick),
      .trig_ev   (trig_ev),
      .cmp       (cmp_vec),
      .cnt       (count),
      .run       (run),
      .match_any (match_any),
      .hw_ovf    (hw_ovf)
   );

   tmr16_out_tog u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tsel      (tsel),
      .match_any (match_any),
      .trig_ev   (trig_ev),
      .tout      (tout)
   );

   // R5: a wrap shows in the readable flag one edge later
   a_r5_ovf_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_ovf && !(ctl_we && ctl_wdata[3:2] == 2'b00)) |=> ctl_rdata[0]);

endmodule

// File: tb/evt_timer16_test.sv
`timescale 1ns/1ps
module evt_timer16_test;

   localparam int W = 8;
   localparam logic [W-1:0] MAXV = '1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_tick = 1'b0;
   logic         trig_in = 1'b0;
   logic [1:0]   trig_edge_sel = 2'b01;
   logic [W-1:0] cmp0 = '0;
   logic [W-1:0] cmp1 = '0;
   logic         ctl_we = 1'b0;
   logic [7:0]   ctl_wdata = '0;
   logic [7:0]   ctl_rdata;
   logic [W-1:0] count;
   logic         tout;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   string cur_req = "R1";

   // bench-side expectation
   logic [W-1:0] e_cnt = '0;
   logic         e_tout = 1'b0;
   logic [1:0]   e_mode = 2'b00;
   logic         e_tsel = 1'b0;
   logic         e_ovf = 1'b0;
   logic         h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;

   always #4 clk = ~clk;

   evt_timer16 #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .trig_in(trig_in),
      .trig_edge_sel(trig_edge_sel), .cmp0(cmp0), .cmp1(cmp1),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .count(count), .tout(tout)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // one clock: predict, clock, compare at the falling edge
   task automatic cycle();
      logic ev, run, m0, m1, rs, hw, flip;
      logic [1:0] nmode;
      // R8: a level applied before edge k is acted on at edge k+2
      case (trig_edge_sel)
         2'b00:   ev = h3 & ~h2;
         2'b01:   ev = ~h3 & h2;
         2'b10:   ev = 1'b0;
         default: ev = h3 ^ h2;
      endcase
      run  = (e_mode != 2'b00);
      m0   = run && cnt_tick && (e_cnt == cmp0);
      m1   = run && cnt_tick && (e_cnt == cmp1);
      rs   = run && ((e_mode == 2'b10 && ev) || (e_mode == 2'b11 && m0));
      hw   = run && cnt_tick && !rs && (e_cnt == MAXV);
      flip = run && (m0 || m1 || (e_tsel && ev));
      nmode = ctl_we ? ctl_wdata[3:2] : e_mode;
      @(posedge clk);
      cyc++;
      if (!run || rs)    e_cnt = '0;
      else if (cnt_tick) e_cnt = e_cnt + 1'b1;
      if (flip) e_tout = ~e_tout;
      if (hw)          e_ovf = 1'b1;
      else if (ctl_we) e_ovf = ctl_wdata[0];
      if (nmode == 2'b00) e_ovf = 1'b0;
      if (ctl_we) e_tsel = ctl_wdata[1];
      e_mode = nmode;
      h3 = h2; h2 = h1; h1 = trig_in;
      @(negedge clk);
      chk(cur_req, "count", int'(count), int'(e_cnt));
      chk(cur_req, "tout", int'(tout), int'(e_tout));
      chk(cur_req, "ctl_rdata", int'(ctl_rdata), int'({4'b0, e_mode, e_tsel, e_ovf}));
   endtask

   task automatic wr(input logic [7:0] d);
      ctl_we = 1'b1; ctl_wdata = d;
      cycle();
      ctl_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "rdata", int'(ctl_rdata), 0);
      chk("R1", "count", int'(count), 0);
      chk("R1", "tout", int'(tout), 0);

      // R2: reserved bits stay zero
      cur_req = "R2";
      wr(8'hF0);
      wr(8'hFA);
      chk("R2", "rsvd", int'(ctl_rdata[7:4]), 0);

      // R7: stop write clears flag even with bit 0 set
      cur_req = "R7";
      wr(8'h05);
      wr(8'h01);
      chk("R7", "ovf", int'(ctl_rdata[0]), 0);

      // R3: halted, ticks and trigger edges ignored
      cur_req = "R3";
      wr(8'h02);
      trig_edge_sel = 2'b11;
      for (int i = 0; i < 24; i++) begin
         cnt_tick = 1'b1;
         trig_in = (i % 4) < 2;
         cycle();
      end
      chk("R3", "count", int'(count), 0);
      chk("R3", "tout", int'(tout), 0);
      trig_in = 1'b0;
      repeat (4) cycle();

      // R4 R10: free running with sparse ticks and two compare points
      cur_req = "R4 R10 R5";
      cmp0 = 8'd20; cmp1 = 8'd50;
      wr(8'h04);
      for (int i = 0; i < 700; i++) begin
         cnt_tick = (i % 3) != 0;
         cycle();
      end
      // both compares equal: one inversion per match
      cmp1 = 8'd20;
      for (int i = 0; i < 300; i++) begin
         cnt_tick = 1'b1;
         cycle();
      end
      cnt_tick = 1'b0;
      repeat (5) cycle();

      // R6: software set and clear, then wrap against a clear
      cur_req = "R6";
      wr(8'h05);
      chk("R6", "sw set", int'(ctl_rdata[0]), 1);
      wr(8'h04);
      chk("R6", "sw clear", int'(ctl_rdata[0]), 0);
      for (int i = 0; i < 300 && e_cnt != MAXV; i++) begin
         cnt_tick = 1'b1;
         cycle();
      end
      ctl_we = 1'b1; ctl_wdata = 8'h04; cnt_tick = 1'b1;
      cycle();
      ctl_we = 1'b0;
      chk("R6", "hw beats sw clear", int'(ctl_rdata[0]), 1);

      // R5: wrap flag in trigger mode with a quiet trigger
      cur_req = "R5";
      wr(8'h08);
      trig_in = 1'b0;
      for (int i = 0; i < 300; i++) begin
         cnt_tick = 1'b1;
         cycle();
      end
      chk("R5", "ovf in trigger mode", int'(ctl_rdata[0]), 1);

      // R8 R11 R12: every edge select, with and without trigger toggle
      cur_req = "R8 R11 R12";
      cmp0 = 8'd200; cmp1 = 8'd201;
      for (int es = 0; es < 4; es++) begin
         for (int ts = 0; ts < 2; ts++) begin
            trig_edge_sel = 2'(es);
            wr(ts != 0 ? 8'h0A : 8'h08);
            for (int i = 0; i < 80; i++) begin
               cnt_tick = (i % 5) != 4;
               if (i % 9 == 0) trig_in = ~trig_in;
               cycle();
            end
         end
      end
      // R11 in free mode too
      trig_edge_sel = 2'b11;
      wr(8'h06);
      for (int i = 0; i < 60; i++) begin
         cnt_tick = 1'b1;
         if (i % 7 == 0) trig_in = ~trig_in;
         cycle();
      end

      // R9: match restart over several compare values
      cur_req = "R9";
      trig_edge_sel = 2'b10;
      cmp1 = 8'd3;
      foreach (cmp_list[k]) begin
         cmp0 = cmp_list[k];
         wr(8'h0C);
         for (int i = 0; i < 600; i++) begin
            cnt_tick = (i % 4) != 3;
            cycle();
         end
      end
      chk("R9", "no ovf from match restart", int'(ctl_rdata[0]), 0);

      // R3: stopping clears the count, output holds
      cur_req = "R3";
      wr(8'h00);
      repeat (10) cycle();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   logic [W-1:0] cmp_list [4] = '{8'd0, 8'd1, 8'd5, 8'd255};

   initial begin
      #(8ns * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule